// File: doc/BRIEF.md
# Three-Channel Interval Timer Bus Register Interface

This block sits between an 8-bit host bus and three interval-timer counter cores. A 2-bit address picks one of four locations: addresses 0, 1 and 2 reach counters 0, 1 and 2, and address 3 takes control words. The block decodes each control word. It keeps a 6-bit configuration for each channel: access format, counting mode and BCD select. It also carries out latch and read-back commands and sequences the byte-wide reads and writes of each 16-bit count. Each counter core is seen only through its live count, its output level and its null-count flag. Loads toward a core leave as a one-cycle strobe with a 16-bit value.

Each channel holds two small state machines. The read pointer has two states. **RP_LO** moves to **RP_HI** when a count byte is read in low-then-high format. **RP_HI** moves back to **RP_LO** on the next such read. The write pointer has two states. **WP_LO** moves to **WP_HI** when the first byte is written in low-then-high format. **WP_HI** moves back to **WP_LO** on the second byte, and that write issues the load. Programming a channel forces both pointers to their LO state. A status latch and a count latch sit ahead of the live count. A pending status is always read first. A latched count holds its value until every byte of it has been read.

Top module: `tmr_bus_regif`

## Requirements
- R1: After reset every channel's configuration is 6'h10: low-byte-only format, mode 0, binary. No latch is pending, both pointers sit at LO, and a read from a counter address returns the low byte of the live count. A read from address 3 returns 8'h00.
- R2: A write to address 3 with bits 7:6 equal to 00, 01 or 10 and bits 5:4 not 00 programs channel 0, 1 or 2. The new configuration takes bits 5:4 as the access format, bits 3:1 as the mode and bit 0 as BCD. The other channels keep their configuration.
- R3: A control word with bits 5:4 equal to 00 latches the live count of the channel that bits 7:6 name. Reads then return the frozen value until it has been fully read, and after that they follow the live count again.
- R4: A count latch or status latch issued to a channel whose previous latch has not yet been fully read has no effect.
- R5: A control word with bits 7:6 equal to 11 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. For every selected channel it latches the count when bit 5 is 0 and the status when bit 4 is 0.
- R6: The status byte holds the output level in bit 7, the null-count flag in bit 6 and the channel's configuration in bits 5:0, all sampled when the latch is taken. When both status and count are pending, the status byte is read first.
- R7: Format 01 returns only the low byte and format 10 returns only the high byte. In both, one read completes the count. Format 11 returns the low byte on one read and the high byte on the next.
- R8: A counter write loads {8'h00,d} in format 01 and {d,8'h00} in format 10. In format 11 the first byte is held and the second byte loads {second,first}. The load strobe rises in the cycle after the completing write and lasts one cycle. No strobe follows the first byte.
- R9: Programming a channel returns its read and write pointers to the low byte and drops any pending count or status latch.
- R10: Writes to counter addresses never change any channel's configuration.
- R11: A latched status byte does not follow later changes of the output level or the null-count flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | 0..2 counter, 3 control |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; the access is consumed at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location |
| core_count | input | 48 | Live counts, channel n at bits 16n+15:16n |
| core_out | input | 3 | Output levels of the counter cores |
| core_null | input | 3 | Null-count flags of the counter cores |
| cfg_mode | output | 9 | Per-channel mode, 3 bits each |
| cfg_fmt | output | 6 | Per-channel access format, 2 bits each |
| cfg_bcd | output | 3 | Per-channel BCD select |
| load_stb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | Load value per channel, 16 bits each |

## Verification
The assertions check a set of properties on every cycle:
- at most one channel is programmed per control write;
- a pending count latch keeps its value;
- a status latch captures the output level and null flag seen at the command;
- programming returns the pointers home and clears the latches;
- the first byte of a low-then-high write gives no load strobe.

Other behaviour needs whole access sequences, so only the bench scenarios can show it. This covers the byte order across several reads and the status-before-count ordering. It also covers the release of a latch back to the live count, ignored second latches, and multi-channel read-back. The bench compares these against a reference model over directed sequences and seeded random traffic.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
    localparam int NUM_CH  = 3;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int CFG_W   = 6;
    localparam int MODE_W  = 3;
    localparam int FMT_W   = 2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;
    localparam logic [CFG_W-1:0] CFG_RESET = 6'b01_000_0;

    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_LO    = 2'b01,
        FMT_HI    = 2'b10,
        FMT_LOHI  = 2'b11
    } acc_fmt_t;

    typedef enum logic { RP_LO, RP_HI } rd_ptr_t;
    typedef enum logic { WP_LO, WP_HI } wr_ptr_t;
endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
    import tmr_regif_pkg::*;
(
    input  logic              ctl_wr,
    input  logic [7:0]        cw,
    output logic [NUM_CH-1:0] prog_sel,
    output logic [NUM_CH-1:0] cnt_lat_sel,
    output logic [NUM_CH-1:0] stat_lat_sel
);
    always_comb begin
        prog_sel     = '0;
        cnt_lat_sel  = '0;
        stat_lat_sel = '0;
        if (ctl_wr) begin
            if (cw[7:6] == 2'b11) begin
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    if (cw[ch+1]) begin
                        cnt_lat_sel[ch]  = !cw[5];
                        stat_lat_sel[ch] = !cw[4];
                    end
                end
            end else begin
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    if (cw[7:6] == 2'(ch)) begin
                        if (cw[5:4] == FMT_LATCH) cnt_lat_sel[ch] = 1'b1;
                        else                      prog_sel[ch]    = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [CFG_W-1:0]  cfg_in,
    input  logic              lat_cnt,
    input  logic              lat_stat,
    input  logic              rd_take,
    input  logic              wr_take,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    input  logic              null_flg,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              ld_pulse,
    output logic [CNT_W-1:0]  ld_val
);
    acc_fmt_t           fmt;
    rd_ptr_t            rd_ptr, rd_ptr_nx;
    wr_ptr_t            wr_ptr, wr_ptr_nx;
    logic               cnt_vld, stat_vld;
    logic [CNT_W-1:0]   cnt_lat;
    logic [BYTE_W-1:0]  stat_q;
    logic [BYTE_W-1:0]  lo_hold;
    logic [CNT_W-1:0]   src;
    logic               cnt_done;

    assign fmt = acc_fmt_t'(cfg_q[5:4]);
    assign cnt_done = rd_take && !stat_vld && (fmt != FMT_LOHI || rd_ptr == RP_HI);

    // next-state logic for both byte pointers
    always_comb begin
        rd_ptr_nx = rd_ptr;
        wr_ptr_nx = wr_ptr;
        if (prog_en) begin
            rd_ptr_nx = RP_LO;
            wr_ptr_nx = WP_LO;
        end else begin
            if (rd_take && !stat_vld && fmt == FMT_LOHI) begin
                unique case (rd_ptr)
                    RP_LO: rd_ptr_nx = RP_HI;
                    RP_HI: rd_ptr_nx = RP_LO;
                endcase
            end
            if (wr_take && fmt == FMT_LOHI) begin
                unique case (wr_ptr)
                    WP_LO: wr_ptr_nx = WP_HI;
                    WP_HI: wr_ptr_nx = WP_LO;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= RP_LO;
            wr_ptr <= WP_LO;
        end else begin
            rd_ptr <= rd_ptr_nx;
            wr_ptr <= wr_ptr_nx;
        end
    end

    // configuration, latches and load outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= CFG_RESET;
            cnt_vld  <= 1'b0;
            stat_vld <= 1'b0;
            cnt_lat  <= '0;
            stat_q   <= '0;
            lo_hold  <= '0;
            ld_pulse <= 1'b0;
            ld_val   <= '0;
        end else begin
            ld_pulse <= 1'b0;
            if (prog_en) begin
                cfg_q    <= cfg_in;
                cnt_vld  <= 1'b0;
                stat_vld <= 1'b0;
            end else begin
                if (lat_cnt && !cnt_vld) begin
                    cnt_vld <= 1'b1;
                    cnt_lat <= live_cnt;
                end else if (cnt_done) begin
                    cnt_vld <= 1'b0;
                end
                if (lat_stat && !stat_vld) begin
                    stat_vld <= 1'b1;
                    stat_q   <= {out_lvl, null_flg, cfg_q};
                end else if (rd_take && stat_vld) begin
                    stat_vld <= 1'b0;
                end
            end
            if (wr_take) begin
                unique case (fmt)
                    FMT_LO: begin
                        ld_pulse <= 1'b1;
                        ld_val   <= {{BYTE_W{1'b0}}, wdata};
                    end
                    FMT_HI: begin
                        ld_pulse <= 1'b1;
                        ld_val   <= {wdata, {BYTE_W{1'b0}}};
                    end
                    FMT_LOHI: begin
                        if (wr_ptr == WP_LO) begin
                            lo_hold <= wdata;
                        end else begin
                            ld_pulse <= 1'b1;
                            ld_val   <= {wdata, lo_hold};
                        end
                    end
                    FMT_LATCH: ;
                endcase
            end
        end
    end

    // read data selection
    always_comb begin
        src = cnt_vld ? cnt_lat : live_cnt;
        if (stat_vld) begin
            rd_byte = stat_q;
        end else begin
            case (fmt)
                FMT_HI:   rd_byte = src[CNT_W-1:BYTE_W];
                FMT_LOHI: rd_byte = (rd_ptr == RP_HI) ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
                default:  rd_byte = src[BYTE_W-1:0];
            endcase
        end
    end

    // R3: a pending count latch keeps its value
    p_cnt_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_vld && !prog_en) |=> $stable(cnt_lat));

    // R4: a second latch while one is pending leaves the latched count alone
    p_relatch_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt && cnt_vld && !prog_en) |=> (cnt_vld && $stable(cnt_lat)));

    // R6: a status latch captures the core's level and null flag
    p_stat_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_stat && !stat_vld && !prog_en) |=>
            (rd_byte[7] == $past(out_lvl) && rd_byte[6] == $past(null_flg)));

    // R9: programming sends both pointers home and clears the latches
    p_ptr_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> (rd_ptr == RP_LO && wr_ptr == WP_LO && !cnt_vld && !stat_vld));

    // R8: the first byte of a low-then-high write gives no load strobe
    p_first_byte_noload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && fmt == FMT_LOHI && wr_ptr == WP_LO) |=> !ld_pulse);
endmodule

// File: rtl/tmr_bus_regif.sv
module tmr_bus_regif
    import tmr_regif_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    input  logic [NUM_CH*CNT_W-1:0]   core_count,
    input  logic [NUM_CH-1:0]         core_out,
    input  logic [NUM_CH-1:0]         core_null,
    output logic [NUM_CH*MODE_W-1:0]  cfg_mode,
    output logic [NUM_CH*FMT_W-1:0]   cfg_fmt,
    output logic [NUM_CH-1:0]         cfg_bcd,
    output logic [NUM_CH-1:0]         load_stb,
    output logic [NUM_CH*CNT_W-1:0]   load_val
);
    logic              ctl_wr;
    logic [NUM_CH-1:0] prog_sel, cnt_lat_sel, stat_lat_sel;
    logic [BYTE_W-1:0] rd_byte_a [NUM_CH];

    assign ctl_wr = bus_wr && (bus_addr == ADDR_CTRL);

    tmr_cw_decode u_dec (
        .ctl_wr       (ctl_wr),
        .cw           (bus_wdata),
        .prog_sel     (prog_sel),
        .cnt_lat_sel  (cnt_lat_sel),
        .stat_lat_sel (stat_lat_sel)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CFG_W-1:0] cfg_q;
        logic             sel;
        assign sel = (bus_addr == 2'(ch));

        tmr_chan_port u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .prog_en  (prog_sel[ch]),
            .cfg_in   (bus_wdata[CFG_W-1:0]),
            .lat_cnt  (cnt_lat_sel[ch]),
            .lat_stat (stat_lat_sel[ch]),
            .rd_take  (bus_rd && sel),
            .wr_take  (bus_wr && sel),
            .wdata    (bus_wdata),
            .live_cnt (core_count[ch*CNT_W +: CNT_W]),
            .out_lvl  (core_out[ch]),
            .null_flg (core_null[ch]),
            .cfg_q    (cfg_q),
            .rd_byte  (rd_byte_a[ch]),
            .ld_pulse (load_stb[ch]),
            .ld_val   (load_val[ch*CNT_W +: CNT_W])
        );

        assign cfg_fmt[ch*FMT_W +: FMT_W]    = cfg_q[5:4];
        assign cfg_mode[ch*MODE_W +: MODE_W] = cfg_q[3:1];
        assign cfg_bcd[ch]                   = cfg_q[0];
    end

    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (bus_addr == 2'(ch)) bus_rdata = rd_byte_a[ch];
        end
    end

    // R2: a control word programs at most one channel
    p_one_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prog_sel));

    // R10: counter writes leave every configuration unchanged
    p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_CTRL) |=>
            ($stable(cfg_mode) && $stable(cfg_fmt) && $stable(cfg_bcd)));

    // R8: loads strobe at most one channel per cycle
    p_one_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

    // bus protocol: one access per cycle
    p_bus_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
endmodule

// File: tb/tmr_bus_regif_tb_top.sv
module tmr_bus_regif_tb_top;
    import tmr_regif_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] core_count;
    logic [2:0]  core_out = '0, core_null = '0;
    logic [8:0]  cfg_mode;
    logic [5:0]  cfg_fmt;
    logic [2:0]  cfg_bcd;
    logic [2:0]  load_stb;
    logic [47:0] load_val;

    logic [15:0] live [3];
    logic [5:0]  m_ctrl [3];
    bit          m_cv [3], m_sv [3], m_rp [3], m_wp [3];
    logic [15:0] m_clat [3];
    logic [7:0]  m_stat [3], m_lo [3];
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    assign core_count = {live[2], live[1], live[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_bus_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_count(core_count),
        .core_out(core_out), .core_null(core_null), .cfg_mode(cfg_mode), .cfg_fmt(cfg_fmt),
        .cfg_bcd(cfg_bcd), .load_stb(load_stb), .load_val(load_val)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        logic [15:0] s;
        if (a == 3) return 8'h00;
        if (m_sv[a]) return m_stat[a];
        s = m_cv[a] ? m_clat[a] : live[a];
        case (m_ctrl[a][5:4])
            2'b10:   return s[15:8];
            2'b11:   return m_rp[a] ? s[15:8] : s[7:0];
            default: return s[7:0];
        endcase
    endfunction

    task automatic model_cw(input logic [7:0] w);
        int c;
        if (w[7:6] != 2'b11) begin
            c = int'(w[7:6]);
            if (w[5:4] != 2'b00) begin
                m_ctrl[c] = w[5:0]; m_cv[c] = 0; m_sv[c] = 0; m_rp[c] = 0; m_wp[c] = 0;
            end else if (!m_cv[c]) begin
                m_cv[c] = 1; m_clat[c] = live[c];
            end
        end else begin
            for (int ch = 0; ch < 3; ch++) begin
                if (w[ch+1]) begin
                    if (!w[5] && !m_cv[ch]) begin m_cv[ch] = 1; m_clat[ch] = live[ch]; end
                    if (!w[4] && !m_sv[ch]) begin
                        m_sv[ch] = 1; m_stat[ch] = {core_out[ch], core_null[ch], m_ctrl[ch]};
                    end
                end
            end
        end
    endtask

    task automatic do_read(input int a, input string tag);
        bus_addr = 2'(a); bus_rd = 1'b1;
        #1 chk(tag, {8'h00, bus_rdata}, {8'h00, exp_rd(a)});
        @(posedge clk); #1 bus_rd = 1'b0;
        if (a != 3) begin
            if (m_sv[a]) m_sv[a] = 0;
            else if (m_ctrl[a][5:4] == 2'b11) begin
                if (!m_rp[a]) m_rp[a] = 1;
                else begin m_rp[a] = 0; m_cv[a] = 0; end
            end else m_cv[a] = 0;
        end
        @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input string tag);
        bit          e_stb [3];
        logic [15:0] e_val [3];
        for (int ch = 0; ch < 3; ch++) begin e_stb[ch] = 0; e_val[ch] = '0; end
        bus_addr = 2'(a); bus_wdata = d; bus_wr = 1'b1;
        if (a == 3) model_cw(d);
        else begin
            case (m_ctrl[a][5:4])
                2'b01: begin e_stb[a] = 1; e_val[a] = {8'h00, d}; end
                2'b10: begin e_stb[a] = 1; e_val[a] = {d, 8'h00}; end
                2'b11: begin
                    if (!m_wp[a]) begin m_lo[a] = d; m_wp[a] = 1; end
                    else begin e_stb[a] = 1; e_val[a] = {d, m_lo[a]}; m_wp[a] = 0; end
                end
                default: ;
            endcase
        end
        @(posedge clk); #1 bus_wr = 1'b0;
        for (int ch = 0; ch < 3; ch++) begin
            chk(tag, {15'd0, load_stb[ch]}, {15'd0, e_stb[ch]});
            if (e_stb[ch]) chk(tag, load_val[ch*16 +: 16], e_val[ch]);
            chk(a == 3 ? "R2" : "R10",
                {10'd0, cfg_fmt[ch*2 +: 2], cfg_mode[ch*3 +: 3], cfg_bcd[ch]}, {10'd0, m_ctrl[ch]});
        end
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int ch = 0; ch < 3; ch++) begin
            live[ch] = 16'h1111 * 16'(ch + 1) + 16'h0102;
            m_ctrl[ch] = 6'h10; m_cv[ch] = 0; m_sv[ch] = 0; m_rp[ch] = 0; m_wp[ch] = 0;
            m_lo[ch] = '0; m_clat[ch] = '0; m_stat[ch] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset configuration and read path
        for (int ch = 0; ch < 3; ch++)
            chk("R1", {10'd0, cfg_fmt[ch*2 +: 2], cfg_mode[ch*3 +: 3], cfg_bcd[ch]}, 16'h0010);
        do_read(0, "R1");
        do_read(3, "R1");

        // R2: program ch1 low-then-high, mode 4
        do_write(3, 8'h78, "R2");
        // R8: low-then-high write on ch0
        do_write(3, 8'h34, "R2");
        do_write(0, 8'h0A, "R8");
        do_write(0, 8'h0A, "R8");
        // R7: two-byte read order
        do_read(0, "R7");
        do_read(0, "R7");

        // R3: latch ch1, change live, read frozen then live
        do_write(3, 8'h40, "R3");
        live[1] = 16'hBEEF;
        do_read(1, "R3");
        do_read(1, "R3");
        do_read(1, "R3");

        // R4: second latch ignored while first pending
        do_write(3, 8'hB6, "R2");
        do_write(3, 8'h80, "R4");
        do_read(2, "R4");
        live[2] = 16'h5A5A;
        do_write(3, 8'h80, "R4");
        do_read(2, "R4");
        do_read(2, "R4");

        // R5 R6: read-back of ch0 and ch1 status plus count
        core_out = 3'b011; core_null = 3'b010;
        do_write(3, 8'hC6, "R5");
        live[0] = 16'h7777; live[1] = 16'h8888;
        core_out = 3'b000; core_null = 3'b000;
        for (int i = 0; i < 3; i++) do_read(0, "R6");
        for (int i = 0; i < 3; i++) do_read(1, "R5");

        // R11: status-only read-back of ch2, then inputs change
        core_out = 3'b100; core_null = 3'b100;
        do_write(3, 8'hE8, "R11");
        core_out = 3'b000; core_null = 3'b000;
        do_read(2, "R11");
        do_read(2, "R11");

        // R9: half-done accesses and a pending latch dropped by reprogramming
        do_write(0, 8'h11, "R9");
        do_read(0, "R9");
        do_write(3, 8'h00, "R9");
        do_write(3, 8'h34, "R9");
        do_write(0, 8'h22, "R9");
        do_write(0, 8'h33, "R9");
        do_read(0, "R9");
        do_read(0, "R9");

        // R7 single-byte formats
        do_write(3, 8'h12, "R2");
        do_write(3, 8'h64, "R2");
        do_read(0, "R7");
        do_read(1, "R7");
        do_write(0, 8'h5C, "R8");
        do_write(1, 8'hC5, "R8");

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            int op, a;
            op = int'($urandom_range(0, 9));
            a  = int'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) live[$urandom_range(0, 2)] = 16'($urandom);
            core_out  = 3'($urandom);
            core_null = 3'($urandom);
            if (op < 5)      do_read(a, "R7");
            else if (op < 7) do_write(int'($urandom_range(0, 2)), 8'($urandom), "R8");
            else             do_write(3, 8'($urandom), "R5");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule